// File: doc/BRIEF.md
# Two-Read One-Write Register File on a Shared Memory Port

This block is a 32-entry, 32-bit register file built from a single true dual-port memory, which has only two physical ports. The first memory port never writes and serves read port 1 every cycle. The second memory port is time-shared between the write port and read port 2. A multiplexer driven by the write enable steers either the write address or the read-2 address onto it. Writes and read-2 accesses are treated as mutually exclusive. When a write takes the shared port, the read-2 result for that cycle is missing, and a valid flag reports this.

Both reads are synchronous and return data one cycle after the address is presented. Address 0 always reads as zero. A small state machine tracks what the shared port did on the last edge. Its states are `PB_RESET` (held in reset, no read done yet), `PB_READ` (the shared port performed a read) and `PB_WRITE` (the shared port performed a write). The transitions are: reset goes to `PB_RESET`; from any state, an edge with `wr_en` low goes to `PB_READ`; from any state, an edge with `wr_en` high goes to `PB_WRITE`. The read-2 valid flag is high only in `PB_READ`.

Top module: `shared_port_regfile`

## Requirements
- R1: On a rising edge with `wr_en` high, `wr_data` is stored at `wr_addr`, and later reads of that address on either port return it (address 0 excepted, see R8).
- R2: `rd1_data` after a rising edge equals the word stored at `rd1_addr` at that edge. If the same address is written at that edge, the old word is returned.
- R3: Read port 1 returns the correct word in every cycle, whether or not a write happens in the same cycle.
- R4: When `wr_en` is high, the shared port uses `wr_addr` and `rd2_addr` has no effect. No location other than `wr_addr` changes.
- R5: After a rising edge with `wr_en` low, `rd2_data` equals the word stored at `rd2_addr` at that edge.
- R6: `rd2_valid` is 1 after a rising edge with `wr_en` low and 0 after a rising edge with `wr_en` high.
- R7: After a rising edge with `wr_en` high, `rd2_data` keeps the value it had before that edge.
- R8: Reading address 0 on either port returns zero, even after a write to address 0.
- R9: While `rst_n` is low (asynchronous, active low), `rd1_data`, `rd2_data` and `rd2_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request; takes the shared port |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd1_addr | input | 5 | Read port 1 address |
| rd1_data | output | 32 | Read port 1 data, one cycle latency |
| rd2_addr | input | 5 | Read port 2 address |
| rd2_data | output | 32 | Read port 2 data, one cycle latency |
| rd2_valid | output | 1 | Read port 2 data was read on the last edge |

## Verification
The in-module assertions check the following on every cycle: the valid flag follows the write enable of the previous edge, read-2 data holds across a write, and a zero address yields zero data on the next cycle. Whether the words returned are the right ones can only be shown by the bench's scenarios. The bench fills the whole file and sweeps both read ports over every address. It then interleaves writes with reads at changing addresses and compares against an arithmetic model of the storage. Those scenarios cover read-before-write ordering, writes that land where read 2 did not point, and the read-1 port during writes.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int RF_WORDS = 32;
    localparam int RF_WIDTH = 32;

    typedef enum logic [1:0] {
        PB_RESET = 2'd0,
        PB_READ  = 2'd1,
        PB_WRITE = 2'd2
    } pb_state_t;
endpackage

// File: rtl/rf_dpram.sv
module rf_dpram #(
    parameter int WORDS = 32,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_a,
    input  logic [AW-1:0]    addr_a,
    input  logic [WIDTH-1:0] din_a,
    output logic [WIDTH-1:0] dout_a,
    input  logic             we_b,
    input  logic [AW-1:0]    addr_b,
    input  logic [WIDTH-1:0] din_b,
    output logic [WIDTH-1:0] dout_b
);
    logic [WIDTH-1:0] mem [WORDS];

    // Storage array: port B write has priority over port A write
    always_ff @(posedge clk) begin
        if (we_b)
            mem[addr_b] <= din_b;
        else if (we_a)
            mem[addr_a] <= din_a;
    end

    // Port A output register: read-first, updates only on read cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dout_a <= '0;
        else if (!we_a)
            dout_a <= mem[addr_a];
    end

    // Port B output register: read-first, updates only on read cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dout_b <= '0;
        else if (!we_b)
            dout_b <= mem[addr_b];
    end

    // R7: a write cycle on port B leaves its output register untouched
    assert_portb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we_b |=> $stable(dout_b));
endmodule

// File: rtl/rf_portb_ctrl.sv
module rf_portb_ctrl
    import rf_pkg::*;
#(
    parameter int WORDS = 32,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [AW-1:0] rd2_addr,
    output logic [AW-1:0] port_addr,
    output logic          port_we,
    output logic          rd2_valid
);
    pb_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PB_RESET, PB_READ, PB_WRITE:
                state_nx = wr_en ? PB_WRITE : PB_READ;
            default:
                state_nx = PB_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= PB_RESET;
        else
            state <= state_nx;
    end

    // Output process: address steering and valid flag
    always_comb begin
        port_we   = wr_en;
        port_addr = wr_en ? wr_addr : rd2_addr;
        unique case (state)
            PB_READ:  rd2_valid = 1'b1;
            PB_WRITE: rd2_valid = 1'b0;
            default:  rd2_valid = 1'b0;
        endcase
    end

    assert_valid_low_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !rd2_valid);
    assert_valid_high_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> rd2_valid);
endmodule

// File: rtl/rf_zero_mask.sv
module rf_zero_mask #(
    parameter int WORDS = 32,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] data
);
    logic is_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            is_zero <= 1'b1;
        else if (capture)
            is_zero <= (addr == '0);
    end

    assign data = is_zero ? '0 : raw;

    assert_zero_reg_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && addr == '0) |=> (data == '0));
endmodule

// File: rtl/shared_port_regfile.sv
module shared_port_regfile
    import rf_pkg::*;
#(
    parameter int WORDS = RF_WORDS,
    parameter int WIDTH = RF_WIDTH,
    localparam int AW = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd1_addr,
    output logic [WIDTH-1:0] rd1_data,
    input  logic [AW-1:0]    rd2_addr,
    output logic [WIDTH-1:0] rd2_data,
    output logic             rd2_valid
);
    localparam int NPORTS = 2;

    logic [AW-1:0]    pb_addr;
    logic             pb_we;
    logic [NPORTS-1:0]           cap;
    logic [NPORTS-1:0][AW-1:0]   raddr;
    logic [NPORTS-1:0][WIDTH-1:0] raw;
    logic [NPORTS-1:0][WIDTH-1:0] masked;

    rf_portb_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd2_addr  (rd2_addr),
        .port_addr (pb_addr),
        .port_we   (pb_we),
        .rd2_valid (rd2_valid)
    );

    // Port A is read-only: write enable and data tied off
    rf_dpram #(.WORDS(WORDS), .WIDTH(WIDTH)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_a   (1'b0),
        .addr_a (rd1_addr),
        .din_a  ({WIDTH{1'b0}}),
        .dout_a (raw[0]),
        .we_b   (pb_we),
        .addr_b (pb_addr),
        .din_b  (wr_data),
        .dout_b (raw[1])
    );

    assign cap[0]   = 1'b1;
    assign cap[1]   = !wr_en;
    assign raddr[0] = rd1_addr;
    assign raddr[1] = rd2_addr;

    for (genvar p = 0; p < NPORTS; p++) begin : g_mask
        rf_zero_mask #(.WORDS(WORDS), .WIDTH(WIDTH)) u_mask (
            .clk     (clk),
            .rst_n   (rst_n),
            .capture (cap[p]),
            .addr    (raddr[p]),
            .raw     (raw[p]),
            .data    (masked[p])
        );
    end

    assign rd1_data = masked[0];
    assign rd2_data = masked[1];

    assert_rd2_held_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(rd2_data));
endmodule

// File: tb/sim_shared_port_regfile.sv
module sim_shared_port_regfile;
    localparam int WORDS = 32;
    localparam int WIDTH = 32;
    localparam int AW    = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [AW-1:0]    rd1_addr = '0;
    logic [AW-1:0]    rd2_addr = '0;
    logic [WIDTH-1:0] rd1_data, rd2_data;
    logic             rd2_valid;

    int tests = 0;
    int fails = 0;
    logic [WIDTH-1:0] model [WORDS];
    logic [WIDTH-1:0] exp1, exp2;
    logic             expv;

    always #10 clk = ~clk;

    shared_port_regfile u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .rd2_addr(rd2_addr), .rd2_data(rd2_data), .rd2_valid(rd2_valid)
    );

    task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] expv_i);
        tests++;
        if (act !== expv_i) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv_i);
        end
    endtask

    function automatic logic [WIDTH-1:0] pat(input int k);
        return (k * 32'h0101_0101) ^ 32'h5A00_00C3 ^ (k << 20);
    endfunction

    // Drive at a falling edge, wait for the next falling edge, compute expectations
    task automatic cycle(input logic we, input int wa, input logic [WIDTH-1:0] wd,
                         input int a1, input int a2, input string tag);
        wr_en = we; wr_addr = AW'(wa); wr_data = wd;
        rd1_addr = AW'(a1); rd2_addr = AW'(a2);
        exp1 = (a1 == 0) ? '0 : model[a1];
        if (!we) exp2 = (a2 == 0) ? '0 : model[a2];
        expv = !we;
        @(negedge clk);
        if (we) model[wa] = wd;
        check({tag, " R2/R3/R8 rd1"}, rd1_data, exp1);
        check({tag, " R5/R7/R8 rd2"}, rd2_data, exp2);
        check({tag, " R6 valid"}, {31'd0, rd2_valid}, {31'd0, expv});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) model[i] = 'x;
        exp2 = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 rd1 reset", rd1_data, '0);
        check("R9 rd2 reset", rd2_data, '0);
        check("R9 valid reset", {31'd0, rd2_valid}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R4/R7: fill every word, read 1 parked on address 0, rd2_addr pointing elsewhere
        for (int i = 0; i < WORDS; i++)
            cycle(1'b1, i, pat(i), 0, (i + 9) % WORDS, "fill");
        // R1/R2/R5/R8: full sweep of both read ports
        for (int a = 0; a < WORDS; a++)
            cycle(1'b0, 0, '0, a, WORDS - 1 - a, "sweep");
        // R2 read-first: read 1 on the address being written
        cycle(1'b1, 6, 32'hDEAD_BEEF, 6, 3, "rdfirst");
        cycle(1'b0, 0, '0, 6, 6, "rdafter");
        // R8: write to address 0 stays invisible
        cycle(1'b1, 0, 32'hFFFF_FFFF, 0, 0, "zero");
        cycle(1'b0, 0, '0, 0, 0, "zero");
        // R3/R4/R6/R7: interleaved traffic, back-to-back writes included
        for (int i = 0; i < 96; i++)
            cycle((i % 3 == 0) || (i % 7 == 1), (i * 7) % WORDS, pat(i + 100),
                  (i * 5) % WORDS, (i * 11 + 3) % WORDS, "mix");
        // R4: confirm every location after the traffic
        for (int a = 0; a < WORDS; a++)
            cycle(1'b0, 0, '0, (a + 1) % WORDS, a, "final");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule